// File: doc/BRIEF.md
# Word Block Transfer Controller

This block is a CPU-programmed mover that carries a run of 16-bit words between local memory and an external device. Software writes a first byte address, a last byte address and a control word whose enable bit launches the run. The engine then steps a word counter from the first address to the last one, inclusive. For each word it makes one memory access and one handshake on the device channel that matches the direction.

The memory side is a synchronous port addressed by word. A read that the memory accepts returns its data in the next cycle. The device side has two valid/ready word channels, one outbound and one inbound. The counter only ever moves address bits 13 to 1. The top two bits stay fixed for the whole run, so a run that passes the top of a 16 KB window wraps to the bottom of the same window.

When the last word is done, the engine clears the enable bit and sets a completion flag. Software clears that flag by writing 0 to it. The flag drives an interrupt line through an enable bit.

Top module: `bwx_block_mover`

## Requirements
- R1: After reset the three registers read 0, `irq_o` is low, and `mem_req`, `dev_out_valid` and `dev_in_ready` are low.
- R2: `reg_sel` picks the register: 0 is the first-address register and 1 is the last-address register, both full 16-bit read/write. 2 is the control register, whose bits 15:4 ignore writes and read 0. Code 3 reads 0.
- R3: Addresses are byte addresses and bit 0 is ignored. `mem_addr` carries byte-address bits 15:1. The run covers every word from the first address up to and including the last one, so equal word addresses move exactly one word.
- R4: During a run `mem_addr` bits 14:13 (byte bits 15:14) never change. The count wraps from word offset 0x1FFF to 0x0000 inside the same 16 KB window.
- R5: Control bit 3 sets the direction. With 1, memory words are read (data on `mem_rdata` one cycle after an accepted read) and sent in order on the outbound channel. With 0, inbound words are written to memory in order, with `mem_we` high.
- R6: When the last word's handshake completes, control bit 0 returns to 0 and bit 1 becomes 1. The address registers keep the values software wrote.
- R7: Writing 0 to control bit 1 clears the completion flag. Writing 1 to it leaves the flag unchanged.
- R8: `irq_o` is high exactly when control bit 2 and control bit 1 are both 1.
- R9: A held-off memory grant or device handshake stalls the engine. No word is dropped or repeated, and the pending request and data stay stable.
- R10: Writing the control register with bit 0 at 0 during a run aborts it, without setting the completion flag. Writes during a run that keep bit 0 at 1, or that change the address registers, do not restart, redirect or retarget the active run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select (0 first, 1 last, 2 control) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register value |
| irq_o | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 16 | Read data, one cycle after an accepted read |
| dev_out_valid | output | 1 | Outbound word valid |
| dev_out_ready | input | 1 | Device takes the outbound word |
| dev_out_data | output | 16 | Outbound word |
| dev_in_valid | input | 1 | Inbound word valid |
| dev_in_ready | output | 1 | Engine takes the inbound word |
| dev_in_data | input | 16 | Inbound word |

## Verification
The bench aims at the inclusive end of the range, using a one-word run with an odd first address; an exclusive compare would move nothing or run away. It checks a run that crosses the top of a 16 KB window: a counter that carried into bit 14 would leave the window instead of wrapping to its base. It throttles grants and handshakes to catch repeated or skipped words, and checks that a write of 1 to the flag cannot clear it. The last scenario stalls the device, then rewrites the addresses and direction during the run and aborts. A design that reloaded on those writes would change the outbound word, and one that flagged an abort as a completion would show bit 1 set.

// File: rtl/bwx_pkg.sv
// Shared definitions for the word block mover: engine states, register
// select codes and control-word bit positions.
// Assumes a 2-bit register select and a 16-bit control register.
package bwx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_DATA,
        ST_SEND,
        ST_RECV,
        ST_WR_REQ
    } eng_state_t;

    localparam logic [1:0] SEL_FIRST = 2'd0;
    localparam logic [1:0] SEL_LAST  = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    localparam int CB_RUN  = 0;
    localparam int CB_FLAG = 1;
    localparam int CB_IEN  = 2;
    localparam int CB_DIR  = 3;

endpackage

// File: rtl/bwx_regs.sv
// Software-visible register file for the block mover: first/last byte
// address registers and the control word (run, flag, interrupt enable,
// direction). Completion from the engine wins over a same-cycle write.
// Assumes REG_W >= 4; unused control bits read as zero.
module bwx_regs
    import bwx_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             done_set,
    output logic [REG_W-1:0] first_addr,
    output logic [REG_W-1:0] last_addr,
    output logic             run_en,
    output logic             dir_out,
    output logic             irq_en,
    output logic             done_flag,
    output logic             irq_o
);

    logic [REG_W-1:0] ctrl_view;

    // Address registers: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_addr <= '0;
            last_addr  <= '0;
        end else if (reg_we) begin
            if (reg_sel == SEL_FIRST) first_addr <= reg_wdata;
            if (reg_sel == SEL_LAST)  last_addr  <= reg_wdata;
        end
    end

    // Control bits: software writes, then hardware completion on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en    <= 1'b0;
            done_flag <= 1'b0;
            irq_en    <= 1'b0;
            dir_out   <= 1'b0;
        end else begin
            if (reg_we && reg_sel == SEL_CTRL) begin
                run_en    <= reg_wdata[CB_RUN];
                done_flag <= done_flag & reg_wdata[CB_FLAG];
                irq_en    <= reg_wdata[CB_IEN];
                dir_out   <= reg_wdata[CB_DIR];
            end
            if (done_set) begin
                run_en    <= 1'b0;
                done_flag <= 1'b1;
            end
        end
    end

    // Assemble the control word as software sees it.
    always_comb begin
        ctrl_view          = '0;
        ctrl_view[CB_RUN]  = run_en;
        ctrl_view[CB_FLAG] = done_flag;
        ctrl_view[CB_IEN]  = irq_en;
        ctrl_view[CB_DIR]  = dir_out;
    end

    // Read multiplexer.
    always_comb begin
        case (reg_sel)
            SEL_FIRST: reg_rdata = first_addr;
            SEL_LAST:  reg_rdata = last_addr;
            SEL_CTRL:  reg_rdata = ctrl_view;
            default:   reg_rdata = '0;
        endcase
    end

    // Interrupt gate.
    assign irq_o = irq_en & done_flag;

endmodule

// File: rtl/bwx_addr_walk.sv
// Word address walker: loads the word counter and window bits from the
// first byte address, latches the last word offset, steps the counter
// within the window and flags the final word.
// Assumes WIN_W < ADDR_W; byte bit 0 of both addresses is ignored.
module bwx_addr_walk #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-2:0] word_addr,
    output logic              at_last
);

    localparam int CNT_W = WIN_W - 1;
    localparam int TOP_W = ADDR_W - WIN_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] stop_q;
    logic             unused_bits;

    assign unused_bits = ^{first_addr[0], last_addr[0], last_addr[ADDR_W-1:WIN_W]};

    // Offset counter and latched stop offset; only the window bits move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            stop_q <= '0;
        end else if (load) begin
            cnt_q  <= first_addr[WIN_W-1:1];
            stop_q <= last_addr[WIN_W-1:1];
        end else if (step) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    generate
        if (TOP_W > 0) begin : g_window
            logic [TOP_W-1:0] top_q;
            // Window bits, frozen for the whole run.
            always_ff @(posedge clk) begin
                if (!rst_n)    top_q <= '0;
                else if (load) top_q <= first_addr[ADDR_W-1:WIN_W];
            end
            assign word_addr = {top_q, cnt_q};
        end else begin : g_flat
            assign word_addr = cnt_q;
        end
    endgenerate

    // Final word reached.
    assign at_last = (cnt_q == stop_q);

endmodule

// File: rtl/bwx_engine.sv
// Transfer sequencer: one memory access plus one device handshake per
// word, advancing only after both complete. Direction is latched at
// launch; dropping the run bit aborts without reporting completion.
// Assumes memory read data arrives the cycle after an accepted read.
module bwx_engine
    import bwx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              dir_out,
    input  logic              at_last,
    output logic              load,
    output logic              step,
    output logic              done_set,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              dev_out_valid,
    input  logic              dev_out_ready,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_in_valid,
    output logic              dev_in_ready,
    input  logic [DATA_W-1:0] dev_in_data
);

    eng_state_t        st_q, st_d;
    logic              run_dir_q;
    logic [DATA_W-1:0] hold_q;
    logic              word_done;

    // Next-state logic with word completion, launch and abort.
    always_comb begin
        st_d      = st_q;
        load      = 1'b0;
        word_done = 1'b0;
        case (st_q)
            ST_IDLE: if (run_en) begin
                load = 1'b1;
                st_d = dir_out ? ST_RD_REQ : ST_RECV;
            end
            ST_RD_REQ:  if (mem_gnt) st_d = ST_RD_DATA;
            ST_RD_DATA: st_d = ST_SEND;
            ST_SEND:    if (dev_out_ready) word_done = 1'b1;
            ST_RECV:    if (dev_in_valid) st_d = ST_WR_REQ;
            ST_WR_REQ:  if (mem_gnt) word_done = 1'b1;
            default:    st_d = ST_IDLE;
        endcase
        step     = 1'b0;
        done_set = 1'b0;
        if (word_done) begin
            if (at_last) begin
                done_set = 1'b1;
                st_d     = ST_IDLE;
            end else begin
                step = 1'b1;
                st_d = run_dir_q ? ST_RD_REQ : ST_RECV;
            end
        end
        if (st_q != ST_IDLE && !run_en) begin
            st_d     = ST_IDLE;
            step     = 1'b0;
            done_set = 1'b0;
        end
    end

    // State register and direction latched at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            run_dir_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (load) run_dir_q <= dir_out;
        end
    end

    // Word holding register fed by memory or the inbound channel.
    always_ff @(posedge clk) begin
        if (!rst_n)                                hold_q <= '0;
        else if (st_q == ST_RD_DATA)               hold_q <= mem_rdata;
        else if (st_q == ST_RECV && dev_in_valid)  hold_q <= dev_in_data;
    end

    assign busy          = (st_q != ST_IDLE);
    assign mem_req       = (st_q == ST_RD_REQ) || (st_q == ST_WR_REQ);
    assign mem_we        = (st_q == ST_WR_REQ);
    assign mem_wdata     = hold_q;
    assign dev_out_valid = (st_q == ST_SEND);
    assign dev_out_data  = hold_q;
    assign dev_in_ready  = (st_q == ST_RECV);

endmodule

// File: rtl/bwx_block_mover.sv
// Top of the word block mover: register file, address walker and
// transfer sequencer. Addresses are bytes; memory is addressed by word.
// Assumes ADDR_W-bit registers and a window of 2**WIN_W bytes.
module bwx_block_mover #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int WIN_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-2:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              dev_out_valid,
    input  logic              dev_out_ready,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_in_valid,
    output logic              dev_in_ready,
    input  logic [DATA_W-1:0] dev_in_data
);

    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] last_addr;
    logic              ctl_run;
    logic              ctl_dir;
    logic              ctl_ie;
    logic              ctl_done;
    logic              done_set;
    logic              load;
    logic              step;
    logic              at_last;
    logic              busy;

    bwx_regs #(.REG_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .done_set   (done_set),
        .first_addr (first_addr),
        .last_addr  (last_addr),
        .run_en     (ctl_run),
        .dir_out    (ctl_dir),
        .irq_en     (ctl_ie),
        .done_flag  (ctl_done),
        .irq_o      (irq_o)
    );

    bwx_addr_walk #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .first_addr (first_addr),
        .last_addr  (last_addr),
        .word_addr  (mem_addr),
        .at_last    (at_last)
    );

    bwx_engine #(.DATA_W(DATA_W)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en        (ctl_run),
        .dir_out       (ctl_dir),
        .at_last       (at_last),
        .load          (load),
        .step          (step),
        .done_set      (done_set),
        .busy          (busy),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_wdata     (mem_wdata),
        .mem_gnt       (mem_gnt),
        .mem_rdata     (mem_rdata),
        .dev_out_valid (dev_out_valid),
        .dev_out_ready (dev_out_ready),
        .dev_out_data  (dev_out_data),
        .dev_in_valid  (dev_in_valid),
        .dev_in_ready  (dev_in_ready),
        .dev_in_data   (dev_in_data)
    );

endmodule

// File: rtl/bwx_mover_chk.sv
// Property checker for the block mover, attached by bind. Watches the
// ports plus the busy and control-flag nets of the top module.
module bwx_mover_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int WIN_W  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              ctl_ie,
    input logic              ctl_done,
    input logic              irq_o,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-2:0] mem_addr,
    input logic              dev_out_valid,
    input logic              dev_out_ready,
    input logic [DATA_W-1:0] dev_out_data,
    input logic              dev_in_ready
);

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_ie |-> !irq_o);

    // R6
    flag_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_done) |-> $past(busy));

    // R4
    window_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-2:WIN_W-1]));

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (!busy || (mem_req && $stable(mem_addr))));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_valid && !dev_out_ready) |=>
            (!busy || (dev_out_valid && $stable(dev_out_data))));

    // R5
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && (dev_out_valid || dev_in_ready)));

endmodule

bind bwx_block_mover bwx_mover_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .ctl_ie        (ctl_ie),
    .ctl_done      (ctl_done),
    .irq_o         (irq_o),
    .mem_req       (mem_req),
    .mem_gnt       (mem_gnt),
    .mem_addr      (mem_addr),
    .dev_out_valid (dev_out_valid),
    .dev_out_ready (dev_out_ready),
    .dev_out_data  (dev_out_data),
    .dev_in_ready  (dev_in_ready)
);

// File: tb/test_bwx_block_mover.sv
`timescale 1ns/1ps
module test_bwx_block_mover;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq_o;
    logic        mem_req, mem_we;
    logic [14:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_gnt;
    logic [15:0] mem_rdata = 16'h0;
    logic        dev_out_valid, dev_out_ready;
    logic [15:0] dev_out_data;
    logic        dev_in_valid, dev_in_ready;
    logic [15:0] dev_in_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bwx_block_mover i_bwx_block_mover (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
        .dev_out_data(dev_out_data), .dev_in_valid(dev_in_valid),
        .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data)
    );

    // ---------------- memory and device models ----------------
    int unsigned cyc = 0;
    logic        stall = 1'b0;
    logic        freeze = 1'b0;
    logic [15:0] in_seq = 16'hC000;
    logic [14:0] wr_a [0:63];
    logic [15:0] wr_d [0:63];
    logic [15:0] out_log [0:63];
    int          wr_n = 0;
    int          out_n = 0;

    function automatic logic [15:0] fpat(input logic [14:0] a);
        return {a, 1'b0} ^ 16'h5A3C;
    endfunction

    assign mem_gnt       = !stall || cyc[0];
    assign dev_out_ready = !freeze && (!stall || (cyc % 3 == 2));
    assign dev_in_valid  = !freeze && (!stall || (cyc % 4 == 1));
    assign dev_in_data   = in_seq;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_gnt && !mem_we) mem_rdata <= fpat(mem_addr);
        if (mem_req && mem_gnt && mem_we && wr_n < 64) begin
            wr_a[wr_n] <= mem_addr;
            wr_d[wr_n] <= mem_wdata;
            wr_n <= wr_n + 1;
        end
        if (dev_out_valid && dev_out_ready && out_n < 64) begin
            out_log[out_n] <= dev_out_data;
            out_n <= out_n + 1;
        end
        if (dev_in_valid && dev_in_ready) in_seq <= in_seq + 1;
    end

    // ---------------- helpers ----------------
    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [15:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [15:0] v;
        bit ok = 0;
        for (int i = 0; i < 3000 && !ok; i++) begin
            reg_read(2'd2, v);
            if (!v[0]) ok = 1;
        end
        chk({req, " run ends"}, {31'd0, ok}, 32'd1);
    endtask

    task automatic launch(input logic [15:0] first, input logic [15:0] last,
                          input logic dir, input logic ie);
        reg_write(2'd0, first);
        reg_write(2'd1, last);
        reg_write(2'd2, {12'h0, dir, ie, 1'b0, 1'b1});
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [15:0] v;
        reg_read(2'd0, v); chk("R1 first reg", v, 0);
        reg_read(2'd1, v); chk("R1 last reg", v, 0);
        reg_read(2'd2, v); chk("R1 ctrl reg", v, 0);
        chk("R1 outputs idle", {irq_o, mem_req, dev_out_valid, dev_in_ready}, 0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        reg_write(2'd0, 16'hBEEF); reg_read(2'd0, v); chk("R2 first rw", v, 16'hBEEF);
        reg_write(2'd1, 16'h1234); reg_read(2'd1, v); chk("R2 last rw", v, 16'h1234);
        reg_write(2'd2, 16'hFFF0); reg_read(2'd2, v); chk("R2 reserved bits", v, 0);
        reg_read(2'd3, v); chk("R2 unused select", v, 0);
    endtask

    task automatic t_read_out();
        logic [15:0] v;
        int base = out_n;
        launch(16'h0100, 16'h0106, 1'b1, 1'b0);
        wait_idle("R3");
        chk("R3 word count", out_n - base, 4);
        for (int i = 0; i < 4; i++)
            chk("R5 outbound word", out_log[base + i], fpat(15'h080 + 15'(i)));
        reg_read(2'd2, v); chk("R6 ctrl after run", v, 16'h000A);
        chk("R8 irq masked", irq_o, 0);
        reg_read(2'd0, v); chk("R6 first kept", v, 16'h0100);
        reg_read(2'd1, v); chk("R6 last kept", v, 16'h0106);
    endtask

    task automatic t_single();
        int base = out_n;
        launch(16'h0203, 16'h0202, 1'b1, 1'b0);
        wait_idle("R3 single");
        chk("R3 single count", out_n - base, 1);
        chk("R3 single word", out_log[base], fpat(15'h101));
    endtask

    task automatic t_wrap();
        logic [14:0] exp_a [0:3];
        int base = out_n;
        exp_a[0] = 15'h3FFE; exp_a[1] = 15'h3FFF; exp_a[2] = 15'h2000; exp_a[3] = 15'h2001;
        launch(16'h7FFC, 16'h4002, 1'b1, 1'b0);
        wait_idle("R4");
        chk("R4 wrap count", out_n - base, 4);
        for (int i = 0; i < 4; i++)
            chk("R4 wrap word", out_log[base + i], fpat(exp_a[i]));
    endtask

    task automatic t_write_in();
        logic [15:0] v;
        logic [15:0] s0;
        int base = wr_n;
        @(negedge clk); s0 = in_seq;
        launch(16'h0010, 16'h0014, 1'b0, 1'b1);
        wait_idle("R5 inbound");
        chk("R5 write count", wr_n - base, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R5 write addr", wr_a[base + i], 15'h008 + 15'(i));
            chk("R5 write data", wr_d[base + i], s0 + 16'(i));
        end
        reg_read(2'd2, v); chk("R6 ctrl inbound", v, 16'h0006);
        chk("R8 irq raised", irq_o, 1);
        reg_write(2'd2, 16'h0006); reg_read(2'd2, v);
        chk("R7 write one keeps flag", v, 16'h0006);
        chk("R8 irq still high", irq_o, 1);
        reg_write(2'd2, 16'h0004); reg_read(2'd2, v);
        chk("R7 write zero clears", v, 16'h0004);
        chk("R8 irq dropped", irq_o, 0);
    endtask

    task automatic t_stall();
        logic [15:0] s0;
        int ob = out_n;
        int wb = wr_n;
        @(negedge clk); stall = 1'b1;
        launch(16'h0300, 16'h0308, 1'b1, 1'b0);
        wait_idle("R9 out");
        chk("R9 stalled out count", out_n - ob, 5);
        for (int i = 0; i < 5; i++)
            chk("R9 stalled out word", out_log[ob + i], fpat(15'h180 + 15'(i)));
        @(negedge clk); s0 = in_seq;
        launch(16'h0400, 16'h0408, 1'b0, 1'b0);
        wait_idle("R9 in");
        chk("R9 stalled in count", wr_n - wb, 5);
        for (int i = 0; i < 5; i++) begin
            chk("R9 stalled addr", wr_a[wb + i], 15'h200 + 15'(i));
            chk("R9 stalled data", wr_d[wb + i], s0 + 16'(i));
        end
        @(negedge clk); stall = 1'b0;
    endtask

    task automatic t_abort();
        logic [15:0] v;
        int ob;
        @(negedge clk); freeze = 1'b1;
        launch(16'h0600, 16'h06FE, 1'b1, 1'b0);
        repeat (10) @(negedge clk);
        ob = out_n;
        chk("R10 waiting word", {dev_out_valid, dev_out_data}, {1'b1, fpat(15'h300)});
        reg_write(2'd0, 16'h0500);
        reg_write(2'd2, 16'h0001);
        repeat (3) @(negedge clk);
        chk("R10 no restart", {dev_out_valid, dev_out_data}, {1'b1, fpat(15'h300)});
        chk("R10 no memory access", mem_req, 0);
        reg_read(2'd0, v); chk("R2 first written mid-run", v, 16'h0500);
        reg_write(2'd2, 16'h0000);
        repeat (2) @(negedge clk);
        chk("R10 aborted idle", {dev_out_valid, mem_req, dev_in_ready}, 0);
        reg_read(2'd2, v); chk("R10 no flag on abort", v, 0);
        freeze = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 nothing sent after abort", out_n - ob, 0);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_read_out();
        t_single();
        t_wrap();
        t_write_in();
        t_stall();
        t_abort();
        finish_run();
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule